// File: doc/BRIEF.md
# Double-Buffered Interval Compare Timer

This block is a 16-bit up-counting interval timer with two compare registers. The second compare register sets the length of the interval: when the counter equals it, the counter returns to zero. Each compare register has a comparator, and each comparator gives a one-cycle match pulse. Software reaches the compare values and a small control register through a write-only register port. A value goes in either as one 16-bit write or as two byte writes, low byte first.

The first compare register can have a shadow stage in front of it, switched by a control bit. With the shadow stage off, a write changes the active value at once. With it on, a write only stages the new value. The staged value moves into the active register at the end of an interval, on the same clock edge that clears the counter. Software can therefore retune the first compare point in the middle of an interval, and the current interval never sees a mixed or early value.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: After reset the control register reads as all zeros: the counter holds at zero, buffering is off, and neither match output pulses.
- R2: While the run bit (control bit 0) is 1, the counter increases by one per clock. While it is 0, the counter holds its value and no match pulse appears.
- R3: When the counter equals compare B while running, the counter is zero on the next cycle, so the interval is B+1 cycles.
- R4: `match_a_o` and `match_b_o` are high exactly in the cycles where the running counter equals compare A or compare B.
- R5: A byte write to the low offset (0 for A, 2 for B) only stages the low byte and has no effect on compare behaviour. A byte write to the high offset (1 for A, 3 for B) commits the staged low byte and the new high byte together.
- R6: A write with `wr_wide` high to offset 0 or 2 commits all 16 bits in one cycle.
- R7: With the shadow bit (control bit 1) at 0, a committed A value updates both the staging shadow and the active compare A, effective from the next cycle.
- R8: With the shadow bit at 1, a committed A value reaches only the shadow; the active compare A is unchanged until the next B match.
- R9: With the shadow bit at 1, the shadow value is copied into the active compare A on the same edge at which the B match clears the counter.
- R10: Offset 4 is the control register (bits 1:0). Writes to offsets 5 to 7 have no effect, and a wide write to any offset other than 0 or 2 is treated as a byte write of `wr_data[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_wide | input | 1 | 16-bit write at an even compare offset |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 16 | Write data (the low byte for byte writes) |
| match_a_o | output | 1 | Counter equals compare A pulse |
| match_b_o | output | 1 | Counter equals compare B pulse (end of interval) |

## Verification
The bench writes a new A value in the very cycle that B matches, with buffering on and with it off. A design that lets a buffered write reach the active register early would move the current interval's A pulse. A design that copies from the shadow one cycle late would leave the next interval on the old value. A lone low-byte write in the middle of a run must leave the A pulse where it was, which catches a design that commits each half as it arrives. Stopping the counter, writing unused offsets, and holding the timer in reset must all leave the pulse spacing unchanged, which exposes any leak from the control decode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_OFS   = 4;
  localparam int RUN_BIT    = 0;
  localparam int SHADOW_BIT = 1;
  localparam int NUM_CMP    = 2;

  typedef struct packed {
    logic shadow_en;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_wide_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              xfer_i,
  output logic [CNT_W-1:0]  cmp_a_o,
  output logic [CNT_W-1:0]  cmp_b_o,
  output logic [CNT_W-1:0]  shadow_a_o,
  output logic              run_o,
  output logic              shadow_en_o,
  output logic              commit_a_o
);
  localparam int BYTE_W = CNT_W / 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

  logic [NUM_CMP-1:0]            commit;
  logic [NUM_CMP-1:0][CNT_W-1:0] commit_val;

  // per-channel decode and low-byte staging
  for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 * ch);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 * ch + 1);

    logic             lo_hit;
    logic             hi_hit;
    logic             stage_en;
    logic [BYTE_W-1:0] stage_q;

    assign lo_hit   = wr_en_i && (wr_addr_i == LO_ADDR);
    assign hi_hit   = wr_en_i && (wr_addr_i == HI_ADDR);
    assign stage_en = lo_hit && !wr_wide_i;

    assign commit[ch]     = (lo_hit && wr_wide_i) || hi_hit;
    assign commit_val[ch] = hi_hit ? {wr_data_i[BYTE_W-1:0], stage_q} : wr_data_i;

    always_ff @(posedge clk) begin
      if (stage_en) stage_q <= wr_data_i[BYTE_W-1:0];
    end
  end

  // control register
  tmr_ctrl_t ctrl_q, ctrl_d;
  logic      ctrl_en;

  always_comb begin
    ctrl_en            = wr_en_i && (wr_addr_i == CTRL_ADDR);
    ctrl_d.run         = wr_data_i[RUN_BIT];
    ctrl_d.shadow_en   = wr_data_i[SHADOW_BIT];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // compare A: shadow plus active, compare B: single register
  logic [CNT_W-1:0] shadow_q, act_q, cmpb_q;
  logic [CNT_W-1:0] act_d;
  logic             act_en, shadow_en_w, cmpb_en;

  always_comb begin
    shadow_en_w = commit[0];
    cmpb_en     = commit[1];
    if (ctrl_q.shadow_en) begin
      act_en = xfer_i;
      act_d  = shadow_q;
    end else begin
      act_en = commit[0];
      act_d  = commit_val[0];
    end
  end

  always_ff @(posedge clk) begin
    if (shadow_en_w) shadow_q <= commit_val[0];
    if (act_en)      act_q    <= act_d;
    if (cmpb_en)     cmpb_q   <= commit_val[1];
  end

  assign cmp_a_o     = act_q;
  assign cmp_b_o     = cmpb_q;
  assign shadow_a_o  = shadow_q;
  assign run_o       = ctrl_q.run;
  assign shadow_en_o = ctrl_q.shadow_en;
  assign commit_a_o  = commit[0];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = run_i;
    cnt_d  = wrap_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W = 16
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] value_i,
  output logic             hit_o
);
  assign hit_o = run_i && (count_i == value_i);
endmodule

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              match_a_o,
  output logic              match_b_o
);
  logic                          rst_sync_n;
  logic                          run, shadow_en, commit_a;
  logic [CNT_W-1:0]              count, cmp_a, cmp_b, shadow_a;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_vals;
  logic [NUM_CMP-1:0]            hit;

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_ni     (rst_n),
    .rst_sync_no(rst_sync_n)
  );

  tmr_regbank #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .wr_en_i    (wr_en),
    .wr_wide_i  (wr_wide),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .xfer_i     (hit[1]),
    .cmp_a_o    (cmp_a),
    .cmp_b_o    (cmp_b),
    .shadow_a_o (shadow_a),
    .run_o      (run),
    .shadow_en_o(shadow_en),
    .commit_a_o (commit_a)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .run_i  (run),
    .wrap_i (hit[1]),
    .count_o(count)
  );

  assign cmp_vals[0] = cmp_a;
  assign cmp_vals[1] = cmp_b;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    tmr_match #(.CNT_W(CNT_W)) u_match (
      .run_i  (run),
      .count_i(count),
      .value_i(cmp_vals[i]),
      .hit_o  (hit[i])
    );
  end

  assign match_a_o = hit[0];
  assign match_b_o = hit[1];
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             shadow_en,
  input logic             commit_a,
  input logic             match_b,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_b,
  input logic [CNT_W-1:0] act_a,
  input logic [CNT_W-1:0] shadow_a
);
  // R2: counting advances by one when not at the interval end
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !match_b) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R2: stopped counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == $past(cnt)));

  // R3: B match clears the counter
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_b |=> (cnt == '0));

  // R4: end-of-interval pulse lasts one cycle
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && (cmp_b != '0)) |=> !match_b);

  // R7: unbuffered commit reaches the active register
  p_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_en && commit_a) |=> (act_a == shadow_a));

  // R8: buffered active register holds between B matches
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !match_b) |=> (act_a == $past(act_a)));

  // R9: buffered transfer on the B match edge
  p_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && match_b) |=> (act_a == $past(shadow_a)));
endmodule

bind dbuf_cmp_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run      (run),
  .shadow_en(shadow_en),
  .commit_a (commit_a),
  .match_b  (match_b_o),
  .cnt      (count),
  .cmp_b    (cmp_b),
  .act_a    (cmp_a),
  .shadow_a (shadow_a)
);

// File: tb/dbuf_cmp_timer_tb.sv
`timescale 1ns/1ps
module dbuf_cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        match_a_o, match_b_o;

  int checks = 0, fails = 0;
  bit chk_on = 1'b0;

  always #2 clk = ~clk;

  dbuf_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .match_a_o(match_a_o), .match_b_o(match_b_o)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt = '0, m_a = '0, m_shd = '0, m_b = '0;
  logic [7:0]  m_sa = '0, m_sb = '0;
  logic        m_run = 1'b0, m_sh = 1'b0;

  always @(posedge clk) begin
    logic hb, ca, cb;
    logic [15:0] va, vb;
    if (!rst_n) begin
      m_cnt = '0; m_run = 1'b0; m_sh = 1'b0;
    end else begin
      hb = m_run && (m_cnt == m_b);
      ca = 1'b0; cb = 1'b0; va = '0; vb = '0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: if (wr_wide) begin ca = 1'b1; va = wr_data; end
          3'd1: begin ca = 1'b1; va = {wr_data[7:0], m_sa}; end
          3'd2: if (wr_wide) begin cb = 1'b1; vb = wr_data; end
          3'd3: begin cb = 1'b1; vb = {wr_data[7:0], m_sb}; end
          default: ;
        endcase
      end
      if (ca && !m_sh)     m_a = va;        // R7
      else if (m_sh && hb) m_a = m_shd;     // R9
      if (ca) m_shd = va;                   // R8
      if (cb) m_b = vb;
      if (m_run) m_cnt = hb ? 16'd0 : m_cnt + 16'd1;
      if (wr_en && wr_addr == 3'd0 && !wr_wide) m_sa = wr_data[7:0];
      if (wr_en && wr_addr == 3'd2 && !wr_wide) m_sb = wr_data[7:0];
      if (wr_en && wr_addr == 3'd4) begin m_run = wr_data[0]; m_sh = wr_data[1]; end
    end
  end

  // per-cycle comparison against the model (R4)
  always @(negedge clk) begin
    if (chk_on) begin
      checks += 2;
      if (match_a_o !== (m_run && m_cnt == m_a)) begin
        fails++;
        $display("FAIL R4 match_a actual %b expected %b", match_a_o, m_run && m_cnt == m_a);
      end
      if (match_b_o !== (m_run && m_cnt == m_b)) begin
        fails++;
        $display("FAIL R4 match_b actual %b expected %b", match_b_o, m_run && m_cnt == m_b);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic w);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_wide = w;
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0;
  endtask

  task automatic do_reset();
    chk_on = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;
  endtask

  // cycles from a B pulse to the following A pulse (A+1 expected)
  task automatic gap(output int n);
    int g = 0;
    do begin @(negedge clk); g++; end while (!match_b_o && g < 100000);
    n = 0;
    do begin @(negedge clk); n++; end while (!match_a_o && n < 100000);
  endtask

  task automatic period(output int n);
    int g = 0;
    do begin @(negedge clk); g++; end while (!match_b_o && g < 100000);
    n = 0;
    do begin @(negedge clk); n++; end while (!match_b_o && n < 100000);
  endtask

  // write A wide in the B-match cycle, then count to the next A pulse
  task automatic write_at_match(input logic [15:0] v, output int n);
    int g = 0;
    do begin @(negedge clk); g++; end while (!match_b_o && g < 100000);
    wr(3'd0, v, 1'b1);
    n = 1;
    while (!match_a_o && n < 100000) begin @(negedge clk); n++; end
  endtask

  // {shadow, wide, a_init, b, a_new, cycles}
  localparam int NV = 6;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'd5,  16'd20, 16'd12, 16'd100},
    {1'b1, 1'b1, 16'd5,  16'd20, 16'd12, 16'd100},
    {1'b0, 1'b0, 16'd3,  16'd9,  16'd7,  16'd80},
    {1'b1, 1'b0, 16'd3,  16'd9,  16'd7,  16'd80},
    {1'b1, 1'b1, 16'd0,  16'd15, 16'd15, 16'd90},
    {1'b0, 1'b1, 16'd40, 16'd40, 16'd2,  16'd150}
  };

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v, input logic w);
    if (w) wr(lo, v, 1'b1);
    else begin wr(lo, {8'd0, v[7:0]}, 1'b0); wr(lo + 3'd1, {8'd0, v[15:8]}, 1'b0); end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, pa, pb;
    @(negedge clk);

    // R1: reset state, no pulses while idle
    do_reset();
    pa = 0; pb = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (match_a_o) pa++;
      if (match_b_o) pb++;
    end
    check("R1 match_a pulses after reset", pa, 0);
    check("R1 match_b pulses after reset", pb, 0);

    // vector table: R6/R7/R8/R9 via the model under several patterns
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr16(3'd0, VEC[v][63:48], VEC[v][64]);
      wr16(3'd2, VEC[v][47:32], VEC[v][64]);
      wr(3'd4, {14'd0, VEC[v][65], 1'b1}, 1'b0);
      repeat (3) @(negedge clk);
      wr16(3'd0, VEC[v][31:16], VEC[v][64]);
      repeat (int'(VEC[v][15:0])) @(negedge clk);
    end

    // R3 / R5 / R6 / R10 / R2 with A=10, B=30, buffering off
    do_reset();
    wr(3'd0, 16'd10, 1'b1);
    wr(3'd2, 16'd30, 1'b1);
    wr(3'd4, 16'h0001, 1'b0);
    period(n); check("R3 interval length", n, 31);
    wr(3'd0, 16'h0003, 1'b0);
    gap(n); check("R5 low byte alone has no effect", n, 11);
    wr(3'd1, 16'h0000, 1'b0);
    gap(n); check("R5 pair commit", n, 4);
    wr(3'd0, 16'd20, 1'b1);
    gap(n); check("R6 wide write", n, 21);
    wr(3'd5, 16'hFFFF, 1'b1);
    wr(3'd6, 16'hFFFF, 1'b0);
    wr(3'd7, 16'hFFFF, 1'b1);
    gap(n); check("R10 unused offsets A", n, 21);
    period(n); check("R10 unused offsets B", n, 31);
    wr(3'd4, 16'h0000, 1'b0);
    pa = 0; pb = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (match_a_o) pa++;
      if (match_b_o) pb++;
    end
    check("R2 no pulses while stopped", pa + pb, 0);
    wr(3'd4, 16'h0001, 1'b0);
    period(n); check("R2 interval after resume", n, 31);

    // R7: unbuffered write in the B-match cycle applies at once
    do_reset();
    wr(3'd0, 16'd6, 1'b1);
    wr(3'd2, 16'd25, 1'b1);
    wr(3'd4, 16'h0001, 1'b0);
    write_at_match(16'd14, n); check("R7 direct update", n, 15);

    // R8 / R9: buffered write waits for the next B match
    do_reset();
    wr(3'd0, 16'd6, 1'b1);
    wr(3'd2, 16'd25, 1'b1);
    wr(3'd4, 16'h0003, 1'b0);
    write_at_match(16'd14, n); check("R8 active held", n, 7);
    gap(n); check("R9 transfer on B match", n, 15);
    wr(3'd0, 16'h0002, 1'b0);
    wr(3'd1, 16'h0000, 1'b0);
    gap(n); check("R9 byte pair via shadow", n, 3);

    chk_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule